// File: doc/BRIEF.md
# Power Management Interval Timer

This block is a free-running up-counter advanced once per cycle of a slow reference clock, nominally 3.579545 MHz. Software reads it to measure elapsed time. A configuration input sets the visible width: narrow mode shows `NARROW_W` bits and wide mode shows `WIDE_W` bits. The counter always keeps all `WIDE_W` bits internally, so changing the mode never disturbs the count. While the system reports a deep sleep or off state, counting pauses.

A sticky status flag marks each change of the most significant visible bit, whether it rises or falls. Software clears the flag by writing a one to it. A separate clear input, level sensitive and asynchronous, zeroes the count while it is high. Reads are synchronous. `rd_en` captures the count into `rd_data`, and the captured value is visible one cycle later. The block runs entirely in the reference clock domain.

Top module: `pm_timer`

## Requirements
- R1: While running, the count increases by exactly one on every clock edge and wraps at 2^WIDE_W.
- R2: `wide_mode` = 1 selects WIDE_W visible bits and 0 selects NARROW_W visible bits. Changing it does not alter the count and does not set the status flag.
- R3: In narrow mode, bits WIDE_W-1 down to NARROW_W of a read return zero and the lower bits return the count. In wide mode, all bits return the count.
- R4: The status flag is set on the clock edge after the top visible bit (NARROW_W-1 in narrow mode, WIDE_W-1 in wide mode) changes value, for a rising change and for a falling change.
- R5: `sys_state` codes 2 (suspend to RAM), 3 (suspend to disk), 4 (soft off) and 5 (mechanical off) freeze the count. Codes 0, 1, 6 and 7 let it run.
- R6: While `tmr_clr` is high, the count is zero, independent of the clock. This clear never sets the status flag.
- R7: Writes with `wr_sel` = 0 address the count and have no effect on it.
- R8: A write with `wr_sel` = 1 and `wr_bit` = 1 clears the status flag. With `wr_bit` = 0 the write leaves the flag unchanged.
- R9: When a top-bit change and a status clear fall on the same edge, the flag ends up set.
- R10: `rd_data` takes the count view on the edge where `rd_en` is high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; one count per edge |
| rst_n | input | 1 | Asynchronous active-low reset of all state |
| tmr_clr | input | 1 | Asynchronous level clear of the count |
| wide_mode | input | 1 | 1 = WIDE_W-bit view, 0 = NARROW_W-bit view |
| sys_state | input | 3 | System power state code (see R5) |
| rd_en | input | 1 | Capture count into rd_data |
| rd_data | output | WIDE_W | Captured count view |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | 0 = count (ignored), 1 = status |
| wr_bit | input | 1 | Write data bit 0; 1 clears status |
| tmr_sts | output | 1 | Sticky top-bit-change flag |

## Verification
The assertions assume that `tmr_clr` changes only between clock edges and stays at each level for at least a full cycle. They also assume that `sys_state` and the write strobes are stable around each edge. The stimulus meets both assumptions by driving every input at the falling edge and by holding the clear for whole cycles. The bench builds the timer with NARROW_W = 8 and WIDE_W = 12, so both top-bit changes in both directions happen within a few thousand cycles. To get exact read values, it stops the count with a sleep code before each read.

// File: rtl/pm_timer.sv
module pm_timer #(
  parameter int NARROW_W = 24,
  parameter int WIDE_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tmr_clr,
  input  logic              wide_mode,
  input  logic [2:0]        sys_state,
  input  logic              rd_en,
  output logic [WIDE_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic              wr_bit,
  output logic              tmr_sts
);

  localparam int HI_W = WIDE_W - NARROW_W;

  logic [WIDE_W-1:0] cnt;
  logic              top_q;
  logic              mode_q;
  logic              hold;
  logic              top_now;
  logic              tog;
  logic              sts_clr;
  logic [WIDE_W-1:0] view;

  assign hold    = (sys_state >= 3'd2) && (sys_state <= 3'd5);
  assign top_now = wide_mode ? cnt[WIDE_W-1] : cnt[NARROW_W-1];
  assign tog     = (top_now != top_q) && (wide_mode == mode_q);
  assign sts_clr = wr_en && wr_sel && wr_bit;
  assign view    = wide_mode ? cnt : {{HI_W{1'b0}}, cnt[NARROW_W-1:0]};

  always_ff @(posedge clk or negedge rst_n or posedge tmr_clr) begin
    if (!rst_n) begin
      cnt   <= '0;
      top_q <= 1'b0;
    end else if (tmr_clr) begin
      cnt   <= '0;
      top_q <= 1'b0;
    end else begin
      if (!hold) cnt <= cnt + 1'b1;
      top_q <= top_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 1'b0;
      tmr_sts <= 1'b0;
      rd_data <= '0;
    end else begin
      mode_q <= wide_mode;
      if (tog)          tmr_sts <= 1'b1;
      else if (sts_clr) tmr_sts <= 1'b0;
      if (rd_en) rd_data <= view;
    end
  end

endmodule

module pm_timer_chk #(
  parameter int NARROW_W = 24,
  parameter int WIDE_W   = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tmr_clr,
  input logic              wide_mode,
  input logic              rd_en,
  input logic [WIDE_W-1:0] rd_data,
  input logic              wr_en,
  input logic              wr_sel,
  input logic              wr_bit,
  input logic              tmr_sts,
  input logic [WIDE_W-1:0] cnt,
  input logic              hold,
  input logic              tog
);

  p_run_step_r1: assert property (@(posedge clk) disable iff (!rst_n || tmr_clr)
    !hold |=> cnt == $past(cnt) + 1'b1);

  p_narrow_hide_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wide_mode) |=> rd_data[WIDE_W-1:NARROW_W] == '0);

  p_sts_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tog |=> tmr_sts);

  p_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n || tmr_clr)
    hold |=> $stable(cnt));

  p_clr_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_clr |-> cnt == '0);

  p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel && wr_bit && !tog) |=> !tmr_sts);

  p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

endmodule

bind pm_timer pm_timer_chk #(.NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .tmr_clr(tmr_clr), .wide_mode(wide_mode),
  .rd_en(rd_en), .rd_data(rd_data), .wr_en(wr_en), .wr_sel(wr_sel),
  .wr_bit(wr_bit), .tmr_sts(tmr_sts), .cnt(cnt), .hold(hold), .tog(tog)
);

// File: tb/pm_timer_tb.sv
module pm_timer_tb_top;
  localparam int NW = 8;
  localparam int WW = 12;

  logic clk = 1'b0, rst_n = 1'b0, tmr_clr = 1'b0, wide_mode = 1'b0;
  logic [2:0] sys_state = 3'd2;
  logic rd_en = 1'b0, wr_en = 1'b0, wr_sel = 1'b0, wr_bit = 1'b0;
  logic [WW-1:0] rd_data;
  logic tmr_sts;
  int checks = 0, errors = 0;
  logic [WW-1:0] held;

  always #5 clk = ~clk;

  pm_timer #(.NARROW_W(NW), .WIDE_W(WW)) dut_i (
    .clk(clk), .rst_n(rst_n), .tmr_clr(tmr_clr), .wide_mode(wide_mode),
    .sys_state(sys_state), .rd_en(rd_en), .rd_data(rd_data), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_bit(wr_bit), .tmr_sts(tmr_sts)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rd(output logic [WW-1:0] v);
    @(negedge clk) rd_en = 1'b1;
    @(negedge clk) rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic wr(input logic sel, input logic b);
    @(negedge clk) begin wr_en = 1'b1; wr_sel = sel; wr_bit = b; end
    @(negedge clk) wr_en = 1'b0;
  endtask

  task automatic restart();
    @(negedge clk) begin sys_state = 3'd2; tmr_clr = 1'b1; end
    @(negedge clk) tmr_clr = 1'b0;
  endtask

  task automatic run(input int n, input logic [2:0] st);
    @(negedge clk) sys_state = st;
    repeat (n) @(posedge clk);
    @(negedge clk) sys_state = 3'd2;
  endtask

  task automatic t_reset();
    logic [WW-1:0] v;
    chk("R10 reset rd_data", rd_data, 0);
    chk("R4 reset status", tmr_sts, 0);
    rd(v);
    chk("R1 count after reset", v, 0);
  endtask

  task automatic t_count();
    logic [WW-1:0] v;
    wide_mode = 1'b1;
    restart();
    run(37, 3'd0);
    rd(v); chk("R1 count 37", v, 37);
    run(5, 3'd3); run(5, 3'd4); run(5, 3'd5); run(5, 3'd2);
    rd(v); chk("R5 frozen in sleep codes", v, 37);
    run(5, 3'd1); run(5, 3'd6); run(5, 3'd7);
    rd(v); chk("R5 runs in codes 1,6,7", v, 52);
  endtask

  task automatic t_write_ignored();
    logic [WW-1:0] v;
    wr(1'b0, 1'b1);
    rd(v); chk("R7 count write ignored", v, 52);
    held = rd_data;
    run(9, 3'd0);
    chk("R10 rd_data holds without rd_en", rd_data, held);
    rd(v); chk("R10 new capture", v, 61);
  endtask

  task automatic t_width();
    logic [WW-1:0] v;
    wide_mode = 1'b0;
    restart();
    run(300, 3'd0);
    rd(v); chk("R3 narrow hides upper bits", v, 12'h02C);
    @(negedge clk) wide_mode = 1'b1;
    rd(v); chk("R2 wide shows full count", v, 12'h12C);
    @(negedge clk) wide_mode = 1'b0;
  endtask

  task automatic t_status();
    wide_mode = 1'b0;
    wr(1'b1, 1'b1);
    chk("R8 clear status", tmr_sts, 0);
    restart();
    run(120, 3'd0);
    chk("R4 no status before change", tmr_sts, 0);
    run(10, 3'd0);
    chk("R4 status on rise of top bit", tmr_sts, 1);
    wr(1'b1, 1'b0);
    chk("R8 zero write keeps status", tmr_sts, 1);
    wr(1'b1, 1'b1);
    chk("R8 one write clears status", tmr_sts, 0);
    run(100, 3'd0);
    chk("R4 no status while top stays high", tmr_sts, 0);
    run(30, 3'd0);
    chk("R4 status on fall of top bit", tmr_sts, 1);
  endtask

  task automatic t_clear();
    logic [WW-1:0] v;
    wide_mode = 1'b0;
    restart();
    run(200, 3'd0);
    wr(1'b1, 1'b1);
    @(negedge clk) begin tmr_clr = 1'b1; sys_state = 3'd0; end
    repeat (4) @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk) rd_en = 1'b0;
    chk("R6 count zero while clear high", rd_data, 0);
    @(negedge clk) begin tmr_clr = 1'b0; sys_state = 3'd2; end
    repeat (3) @(negedge clk);
    chk("R6 clear sets no status", tmr_sts, 0);
    rd(v); chk("R6 count zero after clear", v, 0);
  endtask

  task automatic t_priority();
    wide_mode = 1'b0;
    restart();
    run(127, 3'd0);
    wr(1'b1, 1'b1);
    @(negedge clk) sys_state = 3'd0;
    @(negedge clk) begin sys_state = 3'd2; wr_en = 1'b1; wr_sel = 1'b1; wr_bit = 1'b1; end
    @(negedge clk) wr_en = 1'b0;
    chk("R9 set wins over clear", tmr_sts, 1);
  endtask

  task automatic t_wide_status();
    logic [WW-1:0] v;
    wide_mode = 1'b0;
    restart();
    run(200, 3'd0);
    wr(1'b1, 1'b1);
    @(negedge clk) wide_mode = 1'b1;
    repeat (4) @(negedge clk);
    chk("R2 mode switch sets no status", tmr_sts, 0);
    restart();
    run(2040, 3'd0);
    chk("R4 wide no status before bit 11", tmr_sts, 0);
    run(10, 3'd0);
    chk("R4 wide status on bit 11", tmr_sts, 1);
    rd(v); chk("R1 wide count 2050", v, 2050);
  endtask

  initial begin : wd
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count();
    t_write_ignored();
    t_width();
    t_status();
    t_clear();
    t_priority();
    t_wide_status();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule